// File: doc/BRIEF.md
# Hot Path Occurrence Filter

This block sits where hot-path digests arrive from a profiling unit. Each digest names a start address, a vector of taken/not-taken branch outcomes and the number of outcomes that are meaningful. The filter holds a small fully associative table keyed by the start address together with the meaningful outcome bits. For each entry it keeps a recurrence count and a flag that says whether a trace has already been built for that path.

Every incoming digest produces one result. A path that is new, or that has not yet recurred often enough, is only acknowledged. A path whose count reaches the programmable threshold is handed on. It is marked for trace building when no trace exists yet, and for a resend of the existing trace when one does. Downstream logic reports back when it has accepted a build request, and that report sets the entry's flag. The table accepts one digest per clock. Results appear a fixed two clock edges after the edge that accepts the digest, in arrival order.

Top module: `hot_path_filter`

## Requirements
- R1: After reset `decValid` and `ackOut` are low and the table is empty, so the first digest of any key misses.
- R2: The lookup key is `msgPc` together with `msgDir` with every bit at position `msgLen` or above forced to zero. Bits at those positions never affect a match. A length of `DIR_W` or more keeps every bit.
- R3: On a miss an entry is allocated with count 1 and its expanded flag clear. While empty entries remain, the lowest-numbered empty entry is used. The result is acknowledge-only and carries that entry's index on `decIdx`.
- R4: On a miss with the table full, the least recently used entry is replaced. Any hit or allocation counts as a use.
- R5: On a hit where count+1 is below `cfgThreshold`, the count grows by one and the result is acknowledge-only with the entry index.
- R6: On a hit where count+1 is at least `cfgThreshold` and the entry is not expanded, the result is `decValid` with `decCode` = 1 (build trace). The count returns to 1.
- R7: On a hit where count+1 is at least `cfgThreshold` and the entry is expanded, the result is `decValid` with `decCode` = 2 (resend trace). The count returns to 1.
- R8: A pulse on `expAccept` sets the expanded flag of entry `expIdx`. If an allocation writes that entry on the same edge, the allocation wins and the flag ends clear.
- R9: A digest accepted on one edge gives exactly one result two edges later. That result is either `ackOut` alone or `decValid` alone. Digests may arrive on consecutive cycles, and their results follow in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msgValid | input | 1 | A digest is present this cycle |
| msgPc | input | PC_W | Start address of the path |
| msgDir | input | DIR_W | Branch outcome bits, bit 0 first |
| msgLen | input | LEN_W | Number of meaningful outcome bits |
| cfgThreshold | input | CNT_W | Recurrence threshold |
| expAccept | input | 1 | Downstream accepted a build request |
| expIdx | input | IDX_W | Entry that the build request named |
| decValid | output | 1 | Build or resend result |
| decCode | output | 2 | 1 = build trace, 2 = resend trace, 0 otherwise |
| decIdx | output | IDX_W | Entry touched by the digest |
| ackOut | output | 1 | Acknowledge-only result |

## Verification
A wrong count, a stale expanded flag or a wrong age order inside the table stays hidden until the same key returns. It then shows as a build, a resend or an acknowledge that was not due, or as a `decIdx` that names the wrong slot after an eviction. That shows up two edges after the repeat digest is accepted. The bench keeps its own timestamp model of the table. It drives repeated keys from a small pool so that hits, threshold crossings and evictions happen often, and it compares every result and index against that model.

// File: rtl/hpf_pkg.sv
package hpf_pkg;

  typedef enum logic [1:0] {
    DEC_ACK    = 2'd0,
    DEC_EXPAND = 2'd1,
    DEC_RESEND = 2'd2
  } decision_e;

  // Strobes from control to the table datapath
  typedef struct packed {
    logic doAlloc;  // write key into target entry, count=1, flag clear
    logic doBump;   // increment the hit entry's count
    logic doReset;  // return the hit entry's count to 1
  } tableStrobe_t;

endpackage

// File: rtl/hpf_table.sv
module hpf_table
  import hpf_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PC_W    = 32,
  parameter int DIR_W   = 16,
  parameter int LEN_W   = $clog2(DIR_W + 1),
  parameter int CNT_W   = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msgValid,
  input  logic [PC_W-1:0]  msgPc,
  input  logic [DIR_W-1:0] msgDir,
  input  logic [LEN_W-1:0] msgLen,
  input  tableStrobe_t     strobe,
  input  logic             expAccept,
  input  logic [IDX_W-1:0] expIdx,
  output logic             hit,
  output logic [CNT_W-1:0] hitCount,
  output logic             hitExp,
  output logic [IDX_W-1:0] targetIdx
);

  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  logic [PC_W-1:0]  stagePc;
  logic [DIR_W-1:0] stageDir;
  logic [DIR_W-1:0] maskedDir;

  logic             entValid [ENTRIES];
  logic [PC_W-1:0]  entPc    [ENTRIES];
  logic [DIR_W-1:0] entDir   [ENTRIES];
  logic [CNT_W-1:0] entCnt   [ENTRIES];
  logic             entExp   [ENTRIES];
  logic [IDX_W-1:0] entAge   [ENTRIES];

  logic [ENTRIES-1:0] matchVec;
  logic [IDX_W-1:0]   matchIdx;
  logic [IDX_W-1:0]   victimIdx;
  logic               touch;
  logic [IDX_W-1:0]   targetAge;

  // Drop outcome bits beyond the stated length
  generate
    for (genvar b = 0; b < DIR_W; b++) begin : g_mask
      assign maskedDir[b] = msgDir[b] & (b < int'(msgLen));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stagePc  <= '0;
      stageDir <= '0;
    end else if (msgValid) begin
      stagePc  <= msgPc;
      stageDir <= maskedDir;
    end
  end

  // One comparator per entry
  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_match
      assign matchVec[e] = entValid[e] && (entPc[e] == stagePc) && (entDir[e] == stageDir);
    end
  endgenerate

  always_comb begin
    matchIdx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (matchVec[e]) matchIdx = IDX_W'(e);
    end
  end

  // Lowest empty slot first, otherwise the oldest entry
  always_comb begin
    logic found;
    victimIdx = '0;
    found     = 1'b0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (!found && !entValid[e]) begin
        victimIdx = IDX_W'(e);
        found     = 1'b1;
      end
    end
    if (!found) begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (entAge[e] == OLDEST) victimIdx = IDX_W'(e);
      end
    end
  end

  assign hit       = |matchVec;
  assign targetIdx = hit ? matchIdx : victimIdx;
  assign hitCount  = entCnt[matchIdx];
  assign hitExp    = entExp[matchIdx];
  assign touch     = strobe.doAlloc | strobe.doBump | strobe.doReset;
  assign targetAge = entAge[targetIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) begin
        entValid[e] <= 1'b0;
        entPc[e]    <= '0;
        entDir[e]   <= '0;
        entCnt[e]   <= '0;
        entExp[e]   <= 1'b0;
        entAge[e]   <= IDX_W'(e);
      end
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (expAccept && expIdx == IDX_W'(e)) entExp[e] <= 1'b1;
        if (IDX_W'(e) == targetIdx) begin
          if (strobe.doAlloc) begin
            entValid[e] <= 1'b1;
            entPc[e]    <= stagePc;
            entDir[e]   <= stageDir;
            entCnt[e]   <= CNT_W'(1);
            entExp[e]   <= 1'b0;
          end else if (strobe.doReset) begin
            entCnt[e] <= CNT_W'(1);
          end else if (strobe.doBump) begin
            entCnt[e] <= entCnt[e] + CNT_W'(1);
          end
        end
        if (touch) begin
          if (IDX_W'(e) == targetIdx) entAge[e] <= '0;
          else if (entAge[e] < targetAge) entAge[e] <= entAge[e] + IDX_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/hpf_ctrl.sv
module hpf_ctrl
  import hpf_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msgValid,
  input  logic [CNT_W-1:0] cfgThreshold,
  input  logic             hit,
  input  logic [CNT_W-1:0] hitCount,
  input  logic             hitExp,
  input  logic [IDX_W-1:0] targetIdx,
  output tableStrobe_t     strobe,
  output logic             decValid,
  output logic [1:0]       decCode,
  output logic [IDX_W-1:0] decIdx,
  output logic             ackOut
);

  logic        stageValid;
  logic [CNT_W:0] nextCnt;
  logic        reached;
  decision_e   decision;

  always_ff @(posedge clk) begin
    if (!rstN) stageValid <= 1'b0;
    else       stageValid <= msgValid;
  end

  assign nextCnt = {1'b0, hitCount} + (CNT_W+1)'(1);
  assign reached = nextCnt >= {1'b0, cfgThreshold};

  always_comb begin
    strobe   = '0;
    decision = DEC_ACK;
    if (stageValid) begin
      if (!hit) begin
        strobe.doAlloc = 1'b1;
      end else if (reached) begin
        strobe.doReset = 1'b1;
        decision       = hitExp ? DEC_RESEND : DEC_EXPAND;
      end else begin
        strobe.doBump = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid <= 1'b0;
      decCode  <= DEC_ACK;
      decIdx   <= '0;
      ackOut   <= 1'b0;
    end else begin
      decValid <= stageValid && (decision != DEC_ACK);
      ackOut   <= stageValid && (decision == DEC_ACK);
      decCode  <= stageValid ? decision : DEC_ACK;
      if (stageValid) decIdx <= targetIdx;
    end
  end

endmodule

// File: rtl/hot_path_filter.sv
module hot_path_filter
  import hpf_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PC_W    = 32,
  parameter int DIR_W   = 16,
  parameter int CNT_W   = 8,
  parameter int LEN_W   = $clog2(DIR_W + 1),
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msgValid,
  input  logic [PC_W-1:0]  msgPc,
  input  logic [DIR_W-1:0] msgDir,
  input  logic [LEN_W-1:0] msgLen,
  input  logic [CNT_W-1:0] cfgThreshold,
  input  logic             expAccept,
  input  logic [IDX_W-1:0] expIdx,
  output logic             decValid,
  output logic [1:0]       decCode,
  output logic [IDX_W-1:0] decIdx,
  output logic             ackOut
);

  tableStrobe_t     strobe;
  logic             tableHit;
  logic [CNT_W-1:0] tableCount;
  logic             tableExp;
  logic [IDX_W-1:0] tableTarget;

  hpf_table #(
    .ENTRIES(ENTRIES), .PC_W(PC_W), .DIR_W(DIR_W),
    .LEN_W(LEN_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_table (
    .clk(clk), .rstN(rstN), .msgValid(msgValid),
    .msgPc(msgPc), .msgDir(msgDir), .msgLen(msgLen),
    .strobe(strobe), .expAccept(expAccept), .expIdx(expIdx),
    .hit(tableHit), .hitCount(tableCount), .hitExp(tableExp),
    .targetIdx(tableTarget)
  );

  hpf_ctrl #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .msgValid(msgValid),
    .cfgThreshold(cfgThreshold), .hit(tableHit), .hitCount(tableCount),
    .hitExp(tableExp), .targetIdx(tableTarget), .strobe(strobe),
    .decValid(decValid), .decCode(decCode), .decIdx(decIdx), .ackOut(ackOut)
  );

endmodule

// File: rtl/hpf_checker.sv
module hpf_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             msgValid,
  input logic             decValid,
  input logic [1:0]       decCode,
  input logic             ackOut,
  input logic             hit,
  input logic [CNT_W-1:0] hitCount,
  input logic             hitExp
);

  assert_single_result_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(decValid && ackOut));

  assert_result_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> ##2 (decValid || ackOut));

  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rstN)
    (decValid || ackOut) |-> $past(msgValid, 2));

  assert_live_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (hitCount != '0));

  assert_expand_fresh_R6: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && decCode == 2'd1) |-> $past(hit && !hitExp));

  assert_resend_built_R7: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && decCode == 2'd2) |-> $past(hit && hitExp));

endmodule

bind hot_path_filter hpf_checker #(.CNT_W(CNT_W)) u_hpf_checker (
  .clk(clk), .rstN(rstN), .msgValid(msgValid), .decValid(decValid),
  .decCode(decCode), .ackOut(ackOut), .hit(tableHit),
  .hitCount(tableCount), .hitExp(tableExp)
);

// File: tb/hot_path_filter_tb.sv
`timescale 1ns/1ps
module hot_path_filter_tb;

  localparam int ENTRIES = 16;
  localparam int PC_W = 32;
  localparam int DIR_W = 16;
  localparam int CNT_W = 8;
  localparam int LEN_W = $clog2(DIR_W + 1);
  localparam int IDX_W = $clog2(ENTRIES);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msgValid = 1'b0;
  logic [PC_W-1:0] msgPc = '0;
  logic [DIR_W-1:0] msgDir = '0;
  logic [LEN_W-1:0] msgLen = '0;
  logic [CNT_W-1:0] cfgThreshold = 8'd3;
  logic expAccept = 1'b0;
  logic [IDX_W-1:0] expIdx = '0;
  logic decValid;
  logic [1:0] decCode;
  logic [IDX_W-1:0] decIdx;
  logic ackOut;

  always #10 clk = ~clk;

  hot_path_filter u_dut (
    .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgPc(msgPc),
    .msgDir(msgDir), .msgLen(msgLen), .cfgThreshold(cfgThreshold),
    .expAccept(expAccept), .expIdx(expIdx), .decValid(decValid),
    .decCode(decCode), .decIdx(decIdx), .ackOut(ackOut)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Reference model: timestamps instead of an age order
  bit             mValid [ENTRIES];
  logic [PC_W-1:0]  mPc  [ENTRIES];
  logic [DIR_W-1:0] mDir [ENTRIES];
  int             mCnt [ENTRIES];
  bit             mExp [ENTRIES];
  int             mLast [ENTRIES];
  int             tick = 0;

  function automatic logic [DIR_W-1:0] keepBits(logic [DIR_W-1:0] d, int len);
    logic [DIR_W-1:0] r;
    for (int b = 0; b < DIR_W; b++) r[b] = (b < len) ? d[b] : 1'b0;
    return r;
  endfunction

  // Returns {code, idx}; code 0 means acknowledge-only
  function automatic logic [1+IDX_W:0] modelStep(logic [PC_W-1:0] pc, logic [DIR_W-1:0] d, int len);
    logic [DIR_W-1:0] k;
    int found;
    int code;
    k = keepBits(d, len);
    found = -1;
    code = 0;
    tick++;
    for (int e = 0; e < ENTRIES; e++)
      if (mValid[e] && mPc[e] == pc && mDir[e] == k) found = e;
    if (found >= 0) begin
      if (mCnt[found] + 1 >= int'(cfgThreshold)) begin
        code = mExp[found] ? 2 : 1;
        mCnt[found] = 1;
      end else begin
        mCnt[found] = mCnt[found] + 1;
      end
    end else begin
      for (int e = ENTRIES - 1; e >= 0; e--) if (!mValid[e]) found = e;
      if (found < 0) begin
        found = 0;
        for (int e = 1; e < ENTRIES; e++) if (mLast[e] < mLast[found]) found = e;
      end
      mValid[found] = 1; mPc[found] = pc; mDir[found] = k;
      mCnt[found] = 1; mExp[found] = 0;
    end
    mLast[found] = tick;
    return {2'(code), IDX_W'(found)};
  endfunction

  task automatic checkResult(logic [1+IDX_W:0] exp, string req);
    logic [1:0] ec;
    ec = exp[1+IDX_W:IDX_W];
    total++;
    if (decValid !== (ec != 0) || ackOut !== (ec == 0) ||
        (ec != 0 && decCode !== ec) || decIdx !== exp[IDX_W-1:0]) begin
      bad++;
      $display("FAIL %s: got valid=%0b ack=%0b code=%0d idx=%0d, expected code=%0d idx=%0d",
               req, decValid, ackOut, decCode, decIdx, ec, exp[IDX_W-1:0]);
    end
  endtask

  task automatic drive(logic [PC_W-1:0] pc, logic [DIR_W-1:0] d, int len);
    msgValid = 1'b1; msgPc = pc; msgDir = d; msgLen = LEN_W'(len);
  endtask

  task automatic sendOne(logic [PC_W-1:0] pc, logic [DIR_W-1:0] d, int len, string req,
                         output logic [1+IDX_W:0] res);
    res = modelStep(pc, d, len);
    @(negedge clk); drive(pc, d, len);
    @(negedge clk); msgValid = 1'b0;
    @(negedge clk); checkResult(res, req);
  endtask

  task automatic acceptExp(int idx);
    @(negedge clk); expAccept = 1'b1; expIdx = IDX_W'(idx); mExp[idx] = 1;
    @(negedge clk); expAccept = 1'b0;
  endtask

  task automatic clearModel();
    for (int e = 0; e < ENTRIES; e++) begin
      mValid[e] = 0; mCnt[e] = 0; mExp[e] = 0; mLast[e] = 0;
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; msgValid = 1'b0; expAccept = 1'b0;
    clearModel();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!finished && cyc < 100000) begin
      @(posedge clk); cyc++;
    end
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [1+IDX_W:0] r;
    logic [1+IDX_W:0] ra;
    logic [1+IDX_W:0] rb;
    void'($urandom(32'd2024));
    doReset();

    // R1: quiet outputs after reset
    @(negedge clk);
    total++;
    if (decValid !== 1'b0 || ackOut !== 1'b0) begin
      bad++;
      $display("FAIL R1: got valid=%0b ack=%0b, expected 0 0", decValid, ackOut);
    end
    // R1 / R3: first digest misses into slot 0
    sendOne(32'h400, 16'h0005, 3, "R1", r);

    // R3: next new key takes slot 1; R5 repeat below threshold acks
    cfgThreshold = 8'd3;
    sendOne(32'h404, 16'h0001, 2, "R3", r);
    sendOne(32'h400, 16'h0005, 3, "R5", r);
    // R6: third arrival reaches threshold 3, not built yet
    sendOne(32'h400, 16'h0005, 3, "R6", r);
    // R2: bits at and above length are ignored, so this hits the same entry
    sendOne(32'h400, 16'hFFFD, 3, "R2", r);
    // R8: build accepted, then R7 resend on next threshold crossing
    acceptExp(0);
    sendOne(32'h400, 16'h0005, 3, "R7", r);

    // R2: full length keeps every bit, distinct keys
    sendOne(32'h408, 16'h8000, 16, "R2", r);
    sendOne(32'h408, 16'h0000, 16, "R2", r);

    // R4: fill table and force eviction of the oldest
    for (int i = 0; i < 18; i++)
      sendOne(32'h2000 + 32'(i) * 4, 16'h0, 0, "R4", r);
    sendOne(32'h400, 16'h0005, 3, "R4", r);

    // R8: allocation on the same edge as the accept wins
    doReset();
    cfgThreshold = 8'd2;
    r = modelStep(32'h700, 16'h0003, 2);
    @(negedge clk); drive(32'h700, 16'h0003, 2);
    @(negedge clk); msgValid = 1'b0; expAccept = 1'b1; expIdx = r[IDX_W-1:0];
    @(negedge clk); expAccept = 1'b0; checkResult(r, "R8");
    sendOne(32'h700, 16'h0003, 2, "R8", r);

    // R9: back-to-back digests, results in order
    ra = modelStep(32'h700, 16'h0003, 2);
    rb = modelStep(32'h700, 16'h0003, 2);
    @(negedge clk); drive(32'h700, 16'h0003, 2);
    @(negedge clk); drive(32'h700, 16'h0003, 2);
    @(negedge clk); msgValid = 1'b0; checkResult(ra, "R9");
    @(negedge clk); checkResult(rb, "R9");

    // R6 with threshold 1: every hit asks for a build
    cfgThreshold = 8'd1;
    sendOne(32'h700, 16'h0003, 2, "R6", r);

    // Constrained random mix (R2..R8)
    doReset();
    cfgThreshold = 8'd3;
    for (int n = 0; n < 500; n++) begin
      logic [PC_W-1:0] pc;
      logic [DIR_W-1:0] d;
      int len;
      if (n % 97 == 0) cfgThreshold = CNT_W'(2 + $urandom % 3);
      pc  = 32'h1000 + 32'($urandom % 6) * 4;
      d   = DIR_W'(($urandom & 32'hFFF0) | ($urandom % 4));
      len = 2 + int'($urandom % 3);
      sendOne(pc, d, len, "R5", r);
      if (r[1+IDX_W:IDX_W] == 2'd1 && ($urandom % 2) == 0)
        acceptExp(int'(r[IDX_W-1:0]));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule